// File: doc/BRIEF.md
# Nonlinear Feedback State Generator

This block holds the 80-bit state of a stream-cipher state generator built as a nonlinear feedback shift register. Software or a neighbouring controller places a key-derived starting state into the register through a parallel, synchronous load. After that, each cycle with the advance strobe raised moves every bit one place toward bit 0. A fixed degree-6 polynomial over eleven taps refills the top position.

The block drives three outputs in the same cycle: the whole state word, the serial bit at position 0, and the feedback bit that the next advance will write into the top position. Downstream keystream filters and monitors read these outputs directly. A load takes priority over an advance. With neither strobe raised, the state is held. An all-zero state is a legal fixed point, because the feedback of zero is zero.

Top module: `nlfsr_core`

## Requirements
- R1: While rst_n is low the state is all zeros, and it stays all zeros on the first cycle after release until a load or an advance changes it.
- R2: When load_en is high at a rising clock edge, the state after that edge equals load_word, whether or not adv_en is also high.
- R3: When adv_en is high and load_en is low at a rising edge, the new state is {fb_bit, old state[79:1]}. Bit 79 is the leftmost (top) position and bit 0 the rightmost.
- R4: When both load_en and adv_en are low at a rising edge, the state keeps its value.
- R5: fb_bit is the XOR of two parts. The linear part covers taps 0, 9, 15, 21, 28, 33, 37, 45, 52, 60 and 63. The product part has eleven AND terms: 9·15, 33·37, 60·63, 21·28·33, 45·52·60, 9·28·45·63, 15·21·60·63, 33·37·52·60, 9·15·21·28·33, 37·45·52·60·63 and 21·28·33·37·45·52. Here n means state bit n.
- R6: serial_bit always equals state bit 0 of the current state word.
- R7: Once the state is all zeros, advancing keeps it all zeros, and fb_bit is 0.
- R8: After a load of word P, the serial bit after k advances equals P[k] for every k from 0 to 79.
- R9: The fb_bit shown in a cycle is the value found in state bit 79 after the next advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears the state |
| load_en | input | 1 | Synchronous parallel load strobe, wins over adv_en |
| load_word | input | 80 | Starting state to load |
| adv_en | input | 1 | Advance strobe: shift one place toward bit 0 |
| state_word | output | 80 | Current register state |
| serial_bit | output | 1 | Current state bit 0 |
| fb_bit | output | 1 | Feedback value for the next advance |

## Verification
The bench builds the block with its default 80-bit width. This is the only width where the fixed taps, which reach up to position 63, sit beside sixteen bits that are pure delay line. With that width a single-bit probe at each tap can isolate every linear tap. Paired and grouped probes then turn on each product term in turn. Long advance runs from pseudo-random loads let the new bit feed back through the taps many times, so that term interactions show up in the bench's own model of the polynomial.

// File: rtl/nlfsr_pkg.sv
package nlfsr_pkg;

  localparam int TAP_SPAN   = 64;
  localparam int NUM_LIN    = 11;
  localparam int NUM_PROD   = 11;

  typedef logic [TAP_SPAN-1:0] tap_mask_t;

  // Single-bit mask builder.
  function automatic tap_mask_t bitm(input int idx);
    tap_mask_t m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction

  // Positions XORed straight into the feedback.
  function automatic tap_mask_t lin_mask();
    return bitm(0) | bitm(9) | bitm(15) | bitm(21) | bitm(28) | bitm(33)
         | bitm(37) | bitm(45) | bitm(52) | bitm(60) | bitm(63);
  endfunction

  // Membership mask of product term k.
  function automatic tap_mask_t prod_mask(input int k);
    case (k)
      0:  return bitm(9)  | bitm(15);
      1:  return bitm(33) | bitm(37);
      2:  return bitm(60) | bitm(63);
      3:  return bitm(21) | bitm(28) | bitm(33);
      4:  return bitm(45) | bitm(52) | bitm(60);
      5:  return bitm(9)  | bitm(28) | bitm(45) | bitm(63);
      6:  return bitm(15) | bitm(21) | bitm(60) | bitm(63);
      7:  return bitm(33) | bitm(37) | bitm(52) | bitm(60);
      8:  return bitm(9)  | bitm(15) | bitm(21) | bitm(28) | bitm(33);
      9:  return bitm(37) | bitm(45) | bitm(52) | bitm(60) | bitm(63);
      default: return bitm(21) | bitm(28) | bitm(33) | bitm(37) | bitm(45) | bitm(52);
    endcase
  endfunction

  // AND of all bits selected by a mask.
  function automatic logic and_sel(input tap_mask_t s, input tap_mask_t m);
    return &(s | ~m);
  endfunction

  // XOR of all bits selected by a mask.
  function automatic logic xor_sel(input tap_mask_t s, input tap_mask_t m);
    return ^(s & m);
  endfunction

endpackage

// File: rtl/nlfsr_feedback.sv
module nlfsr_feedback
  import nlfsr_pkg::*;
#(
  parameter int STATE_W = 80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] state,
  output logic               lin_part,
  output logic               prod_part,
  output logic               fb
);

  tap_mask_t            tap_view;
  logic [NUM_PROD-1:0]  term_hit;

  assign tap_view = state[TAP_SPAN-1:0];
  assign lin_part = xor_sel(tap_view, lin_mask());

  for (genvar k = 0; k < NUM_PROD; k++) begin : g_term
    assign term_hit[k] = and_sel(tap_view, prod_mask(k));
  end

  assign prod_part = ^term_hit;
  assign fb        = lin_part ^ prod_part;

  // R7: zero taps give zero feedback.
  assert_zero_fb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_view == '0) |-> (fb == 1'b0));

  // R5: a term fires only when every one of its tap bits is set.
  assert_term_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    term_hit[0] |-> (state[9] && state[15]));

endmodule

// File: rtl/nlfsr_state_reg.sv
module nlfsr_state_reg #(
  parameter int STATE_W = 80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [STATE_W-1:0] load_word,
  input  logic               adv_en,
  input  logic               fill_bit,
  output logic [STATE_W-1:0] state
);

  logic [STATE_W-1:0] shifted;
  logic               do_load;
  logic               do_adv;

  assign do_load = load_en;
  assign do_adv  = adv_en && !load_en;
  assign shifted = {fill_bit, state[STATE_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state <= '0;
    else if (do_load) state <= load_word;
    else if (do_adv)  state <= shifted;
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (state == $past(load_word)));

  assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !load_en) |=> (state == {$past(fill_bit), $past(state[STATE_W-1:1])}));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_en && !load_en) |=> $stable(state));

  assert_zero_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == '0 && !load_en) |=> (state == '0));

endmodule

// File: rtl/nlfsr_core.sv
module nlfsr_core #(
  parameter int STATE_W = 80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [STATE_W-1:0] load_word,
  input  logic               adv_en,
  output logic [STATE_W-1:0] state_word,
  output logic               serial_bit,
  output logic               fb_bit
);

  logic [STATE_W-1:0] cur_state;
  logic               next_fill;
  logic               lin_part;
  logic               prod_part;

  nlfsr_feedback #(.STATE_W(STATE_W)) u_fb (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (cur_state),
    .lin_part (lin_part),
    .prod_part(prod_part),
    .fb       (next_fill)
  );

  nlfsr_state_reg #(.STATE_W(STATE_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .load_word(load_word),
    .adv_en   (adv_en),
    .fill_bit (next_fill),
    .state    (cur_state)
  );

  assign state_word = cur_state;
  assign serial_bit = cur_state[0];
  assign fb_bit     = next_fill;

  // R9: the advertised feedback bit lands in the top position.
  assert_fb_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !load_en) |=> (state_word[STATE_W-1] == $past(fb_bit)));

  // R6: serial output tracks the low end of the state.
  assert_serial_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !load_en) |=> (serial_bit == $past(state_word[1])));

endmodule

// File: tb/nlfsr_core_test.sv
module nlfsr_core_test;

  localparam int W = 80;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_en = 1'b0;
  logic [W-1:0] load_word = '0;
  logic         adv_en = 1'b0;
  logic [W-1:0] state_word;
  logic         serial_bit;
  logic         fb_bit;

  int vectors = 0;
  int misses  = 0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  always #2 clk = ~clk;

  nlfsr_core #(.STATE_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_word(load_word),
    .adv_en(adv_en), .state_word(state_word), .serial_bit(serial_bit), .fb_bit(fb_bit)
  );

  function automatic logic model_fb(input logic [W-1:0] s);
    logic l, q;
    l = s[63] ^ s[60] ^ s[52] ^ s[45] ^ s[37] ^ s[33] ^ s[28] ^ s[21] ^ s[15] ^ s[9] ^ s[0];
    q = (s[63] & s[60]) ^ (s[37] & s[33]) ^ (s[15] & s[9])
      ^ (s[60] & s[52] & s[45]) ^ (s[33] & s[28] & s[21])
      ^ (s[63] & s[45] & s[28] & s[9]) ^ (s[60] & s[52] & s[37] & s[33])
      ^ (s[63] & s[60] & s[21] & s[15])
      ^ (s[63] & s[60] & s[52] & s[45] & s[37])
      ^ (s[33] & s[28] & s[21] & s[15] & s[9])
      ^ (s[52] & s[45] & s[37] & s[33] & s[28] & s[21]);
    return l ^ q;
  endfunction

  function automatic logic [63:0] xs(input logic [63:0] v);
    logic [63:0] x;
    x = v ^ (v << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  task automatic rnd_word(output logic [W-1:0] w);
    seed = xs(seed);
    w[63:0] = seed;
    seed = xs(seed);
    w[W-1:64] = seed[W-65:0];
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock with the given strobes; inputs change and outputs are read at falling edges.
  task automatic cyc(input logic ld, input logic [W-1:0] w, input logic adv);
    load_en = ld; load_word = w; adv_en = adv;
    @(negedge clk);
    load_en = 1'b0; adv_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 in reset", state_word, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", state_word, '0);
    chk("R6 serial at reset", {79'd0, serial_bit}, '0);
  endtask

  task automatic t_load_hold;
    logic [W-1:0] p;
    rnd_word(p);
    cyc(1'b1, p, 1'b0);
    chk("R2 load", state_word, p);
    cyc(1'b0, '0, 1'b0);
    chk("R4 hold one", state_word, p);
    for (int i = 0; i < 5; i++) cyc(1'b0, '0, 1'b0);
    chk("R4 hold many", state_word, p);
  endtask

  task automatic t_load_priority;
    logic [W-1:0] p;
    rnd_word(p);
    cyc(1'b1, p, 1'b1);
    chk("R2 load over advance", state_word, p);
  endtask

  task automatic t_tap_probe;
    // Every single bit in the tap span: linear taps give 1, others 0.
    for (int i = 0; i < W; i++) begin
      logic [W-1:0] p;
      p = '0; p[i] = 1'b1;
      cyc(1'b1, p, 1'b0);
      chk("R5 single tap", {79'd0, fb_bit}, {79'd0, model_fb(p)});
    end
    // Each product term switched on alone over its own bits.
    begin
      logic [W-1:0] grp [11];
      grp[0] = '0; grp[0][9] = 1; grp[0][15] = 1;
      grp[1] = '0; grp[1][33] = 1; grp[1][37] = 1;
      grp[2] = '0; grp[2][60] = 1; grp[2][63] = 1;
      grp[3] = '0; grp[3][21] = 1; grp[3][28] = 1; grp[3][33] = 1;
      grp[4] = '0; grp[4][45] = 1; grp[4][52] = 1; grp[4][60] = 1;
      grp[5] = '0; grp[5][9] = 1; grp[5][28] = 1; grp[5][45] = 1; grp[5][63] = 1;
      grp[6] = '0; grp[6][15] = 1; grp[6][21] = 1; grp[6][60] = 1; grp[6][63] = 1;
      grp[7] = '0; grp[7][33] = 1; grp[7][37] = 1; grp[7][52] = 1; grp[7][60] = 1;
      grp[8] = '0; grp[8][9] = 1; grp[8][15] = 1; grp[8][21] = 1; grp[8][28] = 1; grp[8][33] = 1;
      grp[9] = '0; grp[9][37] = 1; grp[9][45] = 1; grp[9][52] = 1; grp[9][60] = 1; grp[9][63] = 1;
      grp[10] = '0; grp[10][21] = 1; grp[10][28] = 1; grp[10][33] = 1;
      grp[10][37] = 1; grp[10][45] = 1; grp[10][52] = 1;
      for (int k = 0; k < 11; k++) begin
        cyc(1'b1, grp[k], 1'b0);
        chk("R5 product term", {79'd0, fb_bit}, {79'd0, model_fb(grp[k])});
      end
    end
    cyc(1'b1, {W{1'b1}}, 1'b0);
    chk("R5 all ones", {79'd0, fb_bit}, {79'd0, model_fb({W{1'b1}})});
  endtask

  task automatic t_run(input int steps);
    logic [W-1:0] p, m;
    rnd_word(p);
    cyc(1'b1, p, 1'b0);
    m = p;
    for (int i = 0; i < steps; i++) begin
      logic f;
      f = fb_bit;
      chk("R5 running feedback", {79'd0, fb_bit}, {79'd0, model_fb(m)});
      m = {model_fb(m), m[W-1:1]};
      cyc(1'b0, '0, 1'b1);
      chk("R3 shift", state_word, m);
      chk("R9 fb lands on top", {79'd0, state_word[W-1]}, {79'd0, f});
      chk("R6 serial", {79'd0, serial_bit}, {79'd0, m[0]});
    end
  endtask

  task automatic t_serial_order;
    logic [W-1:0] p;
    rnd_word(p);
    cyc(1'b1, p, 1'b0);
    for (int k = 0; k < W; k++) begin
      chk("R8 serial order", {79'd0, serial_bit}, {79'd0, p[k]});
      cyc(1'b0, '0, 1'b1);
    end
  endtask

  task automatic t_zero;
    cyc(1'b1, '0, 1'b0);
    for (int i = 0; i < 20; i++) cyc(1'b0, '0, 1'b1);
    chk("R7 zero fixed point", state_word, '0);
    chk("R7 zero feedback", {79'd0, fb_bit}, '0);
  endtask

  initial begin
    #400000;
    misses++;
    $display("FAIL watchdog: actual still running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_load_hold();
    t_load_priority();
    t_tap_probe();
    t_run(300);
    t_serial_order();
    t_zero();
    t_run(200);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule